// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller behind a successive-approximation converter. A start strobe launches a conversion. The block then drives the sample strobes for an optional gain stage and for the converter itself. It presents a trial code to the DAC and reads back one comparator bit. It decides one result bit on every half period of the conversion clock, so it works on both edges and resolves two bits per full cycle.

A conversion can be 8 bits or 12 bits wide. When the gain stage is enabled, the stage first samples for half a cycle and then amplifies for one to three cycles. The converter samples only after that. When the last bit has been decided, the code is moved into a result register and a sticky completion flag is raised. The flag stays set until a clear pulse arrives or the next conversion starts. The DAC, comparator and amplifier are analog parts outside the block.

Top module: `sar_seq`

## Requirements
- R1: An asynchronous active-low reset forces the block to idle. While it is low, result, trial code, completion flag, busy and all three strobes read 0.
- R2: With the gain stage bypassed, `conv_smp` is high only during the first half of the first clock cycle after the edge that accepts `start`.
- R3: The trial code tries the most significant bit first, while the converter samples and the half cycle after it. A tried bit is kept when `cmp_in` is 1 (input at or above the DAC code) and cleared otherwise, and the next lower bit becomes the new trial. With an ideal comparator the result therefore equals the input code.
- R4: Without gain, the flag rises N/2+1 clock edges after the accepting edge: 5 edges for N=8 and 7 edges for N=12. The final cycle resolves the last bit and then loads the result.
- R5: With `gain_en`=1, `gain_smp` is high during the first half of cycle 1. `gain_amp` is high for the rest of A cycles, where A is 1, 2, 3 or 3 for `gain_code` 0, 1, 2 or 3. `conv_smp` falls in cycle A+1, and the total latency grows by A edges.
- R6: `res_sel`=1 selects 12 bits and `res_sel`=0 selects 8 bits. An 8-bit result is right-aligned, with `result[11:8]`=0.
- R7: A `start` pulse during a conversion is ignored. `res_sel`, `gain_en` and `gain_code` are captured at the accepting edge, and later changes do not affect the running conversion.
- R8: `busy` is high from the accepting edge until the edge that sets the flag, and it falls on that same edge.
- R9: `done_flag` stays set until `flag_clr` is pulsed. A `start` accepted while the flag is set clears the flag at that edge.
- R10: `result` changes only at the end of a conversion. During a conversion it keeps the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled on the rising edge |
| res_sel | input | 1 | 1 = 12-bit, 0 = 8-bit conversion |
| gain_en | input | 1 | Insert the gain-stage sample and amplify phase |
| gain_code | input | 2 | Gain setting, selects the amplify length |
| flag_clr | input | 1 | Clears the completion flag |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| gain_smp | output | 1 | Gain-stage sample strobe |
| gain_amp | output | 1 | Gain-stage amplify phase |
| conv_smp | output | 1 | Converter sample strobe |
| trial | output | 12 | Trial code to the DAC |
| result | output | 12 | Conversion result register |
| done_flag | output | 1 | Sticky completion flag |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with its default widths of 12 and 8 bits. Both resolutions, all four gain codes and the bypassed gain stage are therefore reachable with a small set of vectors. An ideal comparator follows the trial code, so every run must reproduce its input code exactly. The cases include the all-zero and all-one codes and a lone top bit. The bench counts, for each run, the half cycles in which each strobe is high and the edge on which the flag rises. It also disturbs the start and configuration inputs in the middle of a conversion, asserts reset during a conversion, and checks that the flag stays set until it is cleared.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int GAIN_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_AMP  = 2'd1,
    ST_CONV = 2'd2
  } seq_st_e;

  // amplify cycles minus one: code 0 -> 1 cycle, 1 -> 2, 2 and 3 -> 3
  function automatic logic [GAIN_W-1:0] amp_last_f(input logic [GAIN_W-1:0] code);
    return (code >= GAIN_W'(2)) ? GAIN_W'(2) : code;
  endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_HI = 12,
  parameter int RES_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              res_sel,
  input  logic              gain_en,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              flag_clr,
  input  logic              half_sel,
  output logic              busy,
  output logic              done_flag,
  output logic              load,
  output logic [RES_HI-1:0] load_msb,
  output logic              conv_on,
  output logic              neg_dec,
  output logic              neg_copy,
  output logic              finish,
  output logic              res12,
  output logic              gain_smp,
  output logic              gain_amp,
  output logic              conv_smp
);

  localparam int CNT_W = $clog2(RES_HI / 2 + 1);
  localparam logic [RES_HI-1:0] MSB_HI = RES_HI'(1) << (RES_HI - 1);
  localparam logic [RES_HI-1:0] MSB_LO = RES_HI'(1) << (RES_LO - 1);
  localparam logic [CNT_W-1:0]  LAST_HI = CNT_W'(RES_HI / 2);
  localparam logic [CNT_W-1:0]  LAST_LO = CNT_W'(RES_LO / 2);

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              res_q, res_d;
  logic [GAIN_W-1:0] amp_q, amp_d;
  logic              flag_q, flag_d;
  logic [CNT_W-1:0]  last_cc;

  assign last_cc = res_q ? LAST_HI : LAST_LO;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    res_d    = res_q;
    amp_d    = amp_q;
    flag_d   = flag_q;
    load     = 1'b0;
    finish   = 1'b0;
    load_msb = res_q ? MSB_HI : MSB_LO;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          res_d  = res_sel;
          amp_d  = amp_last_f(gain_code);
          cnt_d  = '0;
          flag_d = 1'b0;
          if (gain_en) begin
            st_d = ST_AMP;
          end else begin
            st_d     = ST_CONV;
            load     = 1'b1;
            load_msb = res_sel ? MSB_HI : MSB_LO;
          end
        end
      end
      ST_AMP: begin
        if (cnt_q == CNT_W'(amp_q)) begin
          st_d  = ST_CONV;
          cnt_d = '0;
          load  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt_q == last_cc) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          finish = 1'b1;
          flag_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (flag_clr && !finish) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      res_q  <= 1'b0;
      amp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      res_q  <= res_d;
      amp_q  <= amp_d;
      flag_q <= flag_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done_flag = flag_q;
  assign res12     = res_q;
  assign conv_on   = (st_q == ST_CONV);
  assign neg_copy  = conv_on && (cnt_q == '0);
  assign neg_dec   = conv_on && (cnt_q != '0);
  assign conv_smp  = neg_copy && !half_sel;
  assign gain_smp  = (st_q == ST_AMP) && (cnt_q == '0) && !half_sel;
  assign gain_amp  = (st_q == ST_AMP) && !((cnt_q == '0) && !half_sel);

  // R8: busy falls on the edge that raises the flag
  a_r8_busy_ends_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));

  // R7: a running conversion is not cut short by further starts
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  // R5: the three strobes never overlap
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gain_smp, gain_amp, conv_smp}));

  // R2: the converter samples only inside a conversion
  a_r2_sample_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_smp || gain_amp || conv_smp) |-> busy);

endmodule

// File: rtl/sar_word.sv
module sar_word #(
  parameter int RES_HI = 12,
  parameter int RES_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_in,
  input  logic              load,
  input  logic [RES_HI-1:0] load_msb,
  input  logic              conv_on,
  input  logic              busy,
  input  logic              neg_dec,
  input  logic              neg_copy,
  input  logic              finish,
  input  logic              res12,
  output logic              half_sel,
  output logic [RES_HI-1:0] trial,
  output logic [RES_HI-1:0] result
);

  logic [RES_HI-1:0] word_p, mask_p, word_n, mask_n, res_q;
  logic [RES_HI-1:0] word_p_d, mask_p_d, word_n_d, mask_n_d;
  logic              tog_p, tog_n;

  // rising-edge half: decide the bit tried in the second half
  always_comb begin
    word_p_d = word_p;
    mask_p_d = mask_p;
    if (load) begin
      word_p_d = load_msb;
      mask_p_d = load_msb;
    end else if (conv_on) begin
      word_p_d = (cmp_in ? word_n : (word_n & ~mask_n)) | (mask_n >> 1);
      mask_p_d = mask_n >> 1;
    end
  end

  // falling-edge half: copy during the sample cycle, decide otherwise
  always_comb begin
    word_n_d = word_n;
    mask_n_d = mask_n;
    if (neg_copy) begin
      word_n_d = word_p;
      mask_n_d = mask_p;
    end else if (neg_dec) begin
      word_n_d = (cmp_in ? word_p : (word_p & ~mask_p)) | (mask_p >> 1);
      mask_n_d = mask_p >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_p <= '0;
      mask_p <= '0;
      res_q  <= '0;
      tog_p  <= 1'b0;
    end else begin
      word_p <= word_p_d;
      mask_p <= mask_p_d;
      tog_p  <= tog_n;
      if (finish) res_q <= word_n;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_n <= '0;
      mask_n <= '0;
      tog_n  <= 1'b0;
    end else begin
      word_n <= word_n_d;
      mask_n <= mask_n_d;
      tog_n  <= tog_p ^ busy;
    end
  end

  assign half_sel = tog_p ^ tog_n;
  assign trial    = half_sel ? word_n : word_p;
  assign result   = res_q;

  // R3: at most one trial bit is pending
  a_r3_single_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_p));

  // R10: the result moves only on the closing edge of a conversion
  a_r10_result_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $past(finish));

  // R6: an 8-bit result leaves the top bits clear
  a_r6_narrow_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !res12) |=> (result[RES_HI-1:RES_LO] == '0));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_HI = 12,
  parameter int RES_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              res_sel,
  input  logic              gain_en,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              flag_clr,
  input  logic              cmp_in,
  output logic              gain_smp,
  output logic              gain_amp,
  output logic              conv_smp,
  output logic [RES_HI-1:0] trial,
  output logic [RES_HI-1:0] result,
  output logic              done_flag,
  output logic              busy
);

  logic              half_sel, load, conv_on, neg_dec, neg_copy, finish, res12;
  logic [RES_HI-1:0] load_msb;

  sar_ctrl #(.RES_HI(RES_HI), .RES_LO(RES_LO)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .res_sel   (res_sel),
    .gain_en   (gain_en),
    .gain_code (gain_code),
    .flag_clr  (flag_clr),
    .half_sel  (half_sel),
    .busy      (busy),
    .done_flag (done_flag),
    .load      (load),
    .load_msb  (load_msb),
    .conv_on   (conv_on),
    .neg_dec   (neg_dec),
    .neg_copy  (neg_copy),
    .finish    (finish),
    .res12     (res12),
    .gain_smp  (gain_smp),
    .gain_amp  (gain_amp),
    .conv_smp  (conv_smp)
  );

  sar_word #(.RES_HI(RES_HI), .RES_LO(RES_LO)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_in   (cmp_in),
    .load     (load),
    .load_msb (load_msb),
    .conv_on  (conv_on),
    .busy     (busy),
    .neg_dec  (neg_dec),
    .neg_copy (neg_copy),
    .finish   (finish),
    .res12    (res12),
    .half_sel (half_sel),
    .trial    (trial),
    .result   (result)
  );

endmodule

// File: tb/sar_seq_test.sv
`timescale 1ns/1ps
module sar_seq_test;

  logic        clk = 1'b0;
  logic        rst_n, start, res_sel, gain_en, flag_clr, cmp_in;
  logic [1:0]  gain_code;
  logic        gain_smp, gain_amp, conv_smp, done_flag, busy;
  logic [11:0] trial, result;
  logic [11:0] vin;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  // ideal comparator against the held input code
  assign cmp_in = (vin >= trial);

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_sel(res_sel),
    .gain_en(gain_en), .gain_code(gain_code), .flag_clr(flag_clr),
    .cmp_in(cmp_in), .gain_smp(gain_smp), .gain_amp(gain_amp),
    .conv_smp(conv_smp), .trial(trial), .result(result),
    .done_flag(done_flag), .busy(busy)
  );

  // {disturb, res12, gain_en, gain_code, vin}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 12'h0A5},
    {1'b0, 1'b1, 1'b0, 2'd0, 12'hB3C},
    {1'b0, 1'b0, 1'b1, 2'd0, 12'h000},
    {1'b0, 1'b1, 1'b1, 2'd1, 12'hFFF},
    {1'b0, 1'b0, 1'b1, 2'd2, 12'h0FF},
    {1'b0, 1'b1, 1'b1, 2'd3, 12'h800},
    {1'b1, 1'b1, 1'b0, 2'd0, 12'h7FF},
    {1'b1, 1'b0, 1'b1, 2'd1, 12'h001},
    {1'b0, 1'b1, 1'b0, 2'd0, 12'h000},
    {1'b0, 1'b0, 1'b0, 2'd0, 12'h080}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_conv(input logic r12, input logic gen, input logic [1:0] code,
                          input logic [11:0] code_in, input logic disturb);
    int a_len, n_bits, lat, cs_cyc, c_cs, c_gs, c_ga, busy_bad;
    logic [11:0] prev, msb_tr;
    logic ended;
    vin = code_in; res_sel = r12; gain_en = gen; gain_code = code;
    prev = result;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    a_len  = gen ? ((code >= 2) ? 3 : code + 1) : 0;
    n_bits = r12 ? 12 : 8;
    lat = -1; cs_cyc = 0; c_cs = 0; c_gs = 0; c_ga = 0; busy_bad = 0;
    msb_tr = '0; ended = 1'b0;
    for (int k = 1; k < 60 && !ended; k++) begin
      if (done_flag) begin
        lat = k - 1;
        ended = 1'b1;
      end else begin
        if (k == 1) chk("R9 flag cleared by start", done_flag, 0);
        if (k == 2) chk("R10 result held during conversion", result, prev);
        if (!busy) busy_bad++;
        if (disturb && k == 2) begin
          start = 1'b1; res_sel = ~r12; gain_en = ~gen; gain_code = ~code;
        end
        if (disturb && k == 3) begin
          start = 1'b0; res_sel = r12; gain_en = gen; gain_code = code;
        end
        if (conv_smp) begin c_cs++; cs_cyc = k; end
        if (gain_smp) c_gs++;
        if (gain_amp) c_ga++;
        #2;
        if (conv_smp) c_cs++;
        if (gain_smp) c_gs++;
        if (gain_amp) c_ga++;
        if (k == cs_cyc) msb_tr = trial;
        @(posedge clk); #1;
      end
    end
    chk("R4/R5 flag latency", lat, a_len + n_bits / 2 + 1);
    chk("R3/R6/R7 result equals input", result, code_in);
    chk("R8 busy low with flag", busy, 0);
    chk("R8 busy high throughout", busy_bad, 0);
    chk("R2 converter sample half cycles", c_cs, 1);
    chk("R2/R5 converter sample cycle", cs_cyc, a_len + 1);
    chk("R3 MSB tried first", msb_tr, 1 << (n_bits - 1));
    chk("R5 gain sample half cycles", c_gs, gen ? 1 : 0);
    chk("R5 gain amplify half cycles", c_ga, gen ? 2 * a_len - 1 : 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; res_sel = 1'b0; gain_en = 1'b0;
    gain_code = 2'd0; flag_clr = 1'b0; vin = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset flag", done_flag, 0);
    chk("R1 reset result", result, 0);
    chk("R1 reset trial", trial, 0);
    chk("R1 reset strobes", {gain_smp, gain_amp, conv_smp}, 0);
    rst_n = 1'b1;

    foreach (VEC[i])
      run_conv(VEC[i][15], VEC[i][14], VEC[i][13:12], VEC[i][11:0], VEC[i][16]);

    // R9: the flag is sticky until cleared
    repeat (5) @(posedge clk);
    #1 chk("R9 flag sticky", done_flag, 1);
    flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    chk("R9 flag cleared by clr", done_flag, 0);
    chk("R10 result kept after clr", result, 12'h080);

    // R1: reset in the middle of a conversion
    vin = 12'h5A5; res_sel = 1'b1; gain_en = 1'b0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 mid reset busy", busy, 0);
    chk("R1 mid reset result", result, 0);
    chk("R1 mid reset trial", trial, 0);
    chk("R1 mid reset strobes", {gain_smp, gain_amp, conv_smp}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 idle after reset", busy, 0);
    run_conv(1'b1, 1'b1, 2'd2, 12'h5A5, 1'b0);

    summary();
  end

endmodule